// File: doc/BRIEF.md
# Page-Mode Bytewide Memory Controller

This block puts an asynchronous SRAM-style parallel port in front of an internal byte array. The port has active-low chip, write and output enables, a 17-bit byte address and an 8-bit data path. A system clock samples every pin. The block times each access in clock cycles and decides when the data bus may be driven. The address splits into a row (upper 14 bits) and a column (lower 3 bits). Once a row is open, a change of column alone gives a short page access. A change of row, or a cycle of chip enable, gives a full access. Raising chip enable starts a precharge interval, and no new access may begin until that interval has passed.

A cycle is a chip-enable-controlled write when write enable is already low as the access starts. It is a write-enable-controlled write when write enable falls later; such a cycle begins life as a read. In both cases the byte is stored on whichever of write enable or chip enable rises first. Each falling edge of write enable inside an open row takes the current column, so a string of write pulses fills one page. Two inputs can block stores without affecting reads: a lockout input and a per-sector protect mask. Each sector is one eighth of the address space.

The data bus is split into an input, an output and an output-enable, which the chip's pad ring combines into the bidirectional pin. The storage is a behavioural model holding 2^MEM_AW bytes. Address bits above the model size are XOR-folded onto the low offset bits, so a full-size array only needs a larger parameter.

Top module: `pgmem_ctrl`

## Requirements
- R1: While reset is held and in the first cycles after it, `dq_oe` is 0. After reset the controller is idle and waits for chip enable to go low.
- R2: A byte stored at an address is the value later read at that address. The row is address bits 16..3 and the column is bits 2..0.
- R3: In an open row with chip enable held low, a change on address bits 2..0 alone starts a page access. The bus is released 3 clock edges after the change and driven again from edge T_PAGE+3 with the new byte. The row stays latched.
- R4: With chip enable held low and write enable high, a change on address bits 16..3 starts a full access. The bus is driven again from edge T_ACC+3 after the change.
- R5: Raising chip enable starts a precharge of T_PRE cycles. An access requested during precharge waits for it to end. If chip enable goes low one clock edge after it rose, the bus is first driven at edge T_PRE+T_ACC+4 counted from the rise.
- R6: The bus is driven only while chip enable is low, output enable is low, write enable is high and the access time has passed. After chip enable falls with output enable already low, `dq_oe` is 0 through edge T_ACC+2 and 1 at edge T_ACC+3. With output enable high the bus stays undriven.
- R7: If write enable is low when the access starts, the cycle is a write, and the bus is not driven while write enable stays low, whatever output enable does.
- R8: If write enable falls after the access started, the bus is released 2 edges after the fall. The stored byte is the data present when the first of write enable or chip enable rises. Later data changes in the same pulse are not stored.
- R9: In an open row, each new write-enable pulse stores one byte at the column present when write enable fell.
- R10: While `wr_lock` is 1, no byte is stored. Reads are unaffected, and stores resume once it returns to 0.
- R11: Bit i of `sect_prot` blocks stores to addresses whose bits 16..14 equal i. Other sectors stay writable, and reads of a protected sector still return its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the pins |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 17 | Byte address; bits 16..3 row, 2..0 column |
| dq_in | input | 8 | Data from the bus pins |
| dq_out | output | 8 | Data toward the bus pins |
| dq_oe | output | 1 | 1 when the block drives the bus |
| wr_lock | input | 1 | 1 blocks all stores |
| sect_prot | input | 8 | Per-sector store block, bit i for sector i |

## Verification
The assertions check the sequencing rules on every cycle. The bus only becomes valid after an access interval, precharge always ends in idle, and the latched row never moves while the row stays open. A store commits at most once per edge, lands exactly where it was aimed, and leaves the array untouched when locked or protected. Only the bench scenarios can show the visible results. These are the exact edge on which the bus appears after a full, page or post-precharge access, and which data value a write captures when the two enables rise in either order. They also cover the bytes a page write leaves behind, and the fact that reads are unaffected by the lockout and the protect mask.

// File: rtl/pgm_pkg.sv
// Shared types for the page-mode memory controller.
// Assumes nothing beyond standard SystemVerilog.
package pgm_pkg;

    // Access sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_OPEN  = 2'd2,
        ST_PRECH = 2'd3
    } acc_state_t;

    // Largest of three cycle counts; sizes the shared timer.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pgm_pin_sync.sv
// Multi-stage sampler for the asynchronous pin bundle.
// All pins travel through the same number of stages, so their relative timing is kept.
// Assumes STAGES >= 1. Reset loads RST_VAL (enables inactive).
module pgm_pin_sync #(
    parameter int              W       = 28,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stg
        if (i == 0) begin : g_first
            // First stage: capture raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= d;
            end
        end else begin : g_next
            // Later stages: shift the sampled bundle on.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pgm_access_fsm.sv
// Access sequencer. It latches the row and column, times full, page and
// precharge intervals, arms and fires byte stores, and decides when the
// bus may be driven.
// Assumes synchronized, glitch-free inputs; T_ACC, T_PAGE and T_PRE are >= 1.
module pgm_access_fsm
    import pgm_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int COL_W  = 3,
    parameter int DATA_W = 8,
    parameter int T_ACC  = 6,
    parameter int T_PAGE = 3,
    parameter int T_PRE  = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_s,
    input  logic              we_s,
    input  logic              oe_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] dq_s,
    output logic [ADDR_W-1:0] acc_idx,
    output logic              wr_go,
    output logic [DATA_W-1:0] wr_data,
    output logic              drive
);

    localparam int ROW_W = ADDR_W - COL_W;
    localparam int MAXT  = max3(T_ACC, T_PAGE, T_PRE);
    localparam int CNT_W = $clog2(MAXT + 1);
    localparam logic [CNT_W-1:0] ACC_LD  = CNT_W'(T_ACC - 1);
    localparam logic [CNT_W-1:0] PAGE_LD = CNT_W'(T_PAGE - 1);
    localparam logic [CNT_W-1:0] PRE_LD  = CNT_W'(T_PRE - 1);

    acc_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             armed;
    logic             we_d, ce_d;

    logic [ROW_W-1:0] row_in;
    logic [COL_W-1:0] col_in;
    logic             we_fall, we_rise, ce_rise, active;

    // Split the pin address and find enable edges.
    always_comb begin
        row_in  = addr_s[ADDR_W-1:COL_W];
        col_in  = addr_s[COL_W-1:0];
        we_fall = !we_s && we_d;
        we_rise = we_s && !we_d;
        ce_rise = ce_s && !ce_d;
        active  = (state == ST_BUSY) || (state == ST_OPEN);
    end

    // Sequencer: state, timer, latched row/column and write arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            row_q <= '0;
            col_q <= '0;
            armed <= 1'b0;
            we_d  <= 1'b1;
            ce_d  <= 1'b1;
        end else begin
            we_d <= we_s;
            ce_d <= ce_s;
            case (state)
                ST_IDLE: begin
                    if (!ce_s) begin
                        state <= ST_BUSY;
                        cnt   <= ACC_LD;
                        row_q <= row_in;
                        col_q <= col_in;
                        armed <= !we_s;
                    end
                end
                ST_BUSY, ST_OPEN: begin
                    if (state == ST_BUSY) begin
                        if (cnt == '0) state <= ST_OPEN;
                        else           cnt   <= cnt - 1'b1;
                    end
                    if (ce_s) begin
                        state <= ST_PRECH;
                        cnt   <= PRE_LD;
                        armed <= 1'b0;
                    end else begin
                        if (we_fall) begin
                            col_q <= col_in;
                            armed <= 1'b1;
                        end
                        if (we_rise) armed <= 1'b0;
                        if (we_s && (row_in != row_q)) begin
                            state <= ST_BUSY;
                            cnt   <= ACC_LD;
                            row_q <= row_in;
                            col_q <= col_in;
                        end else if (we_s && (col_in != col_q)) begin
                            state <= ST_BUSY;
                            col_q <= col_in;
                            cnt   <= (state == ST_OPEN || cnt < PAGE_LD) ? PAGE_LD : cnt;
                        end
                    end
                end
                default: begin
                    if (cnt == '0) state <= ST_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
            endcase
        end
    end

    // Store strobe and bus drive decision.
    always_comb begin
        wr_go   = active && armed && (we_rise || ce_rise);
        wr_data = dq_s;
        acc_idx = {row_q, col_q};
        drive   = (state == ST_OPEN) && !ce_s && !oe_s && we_s;
    end

    // R4: data becomes valid only at the end of a timed access.
    p_open_from_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && $past(state) != ST_OPEN) |-> $past(state) == ST_BUSY);

    // R5: precharge always runs out into idle.
    p_prech_to_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_PRECH && state != ST_PRECH) |-> state == ST_IDLE);

    // R3: the row stays put while the row is open.
    p_row_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && $past(state) == ST_OPEN) |-> $stable(row_q));

    // R8: one store per rising enable.
    p_one_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> !wr_go);

endmodule

// File: rtl/pgm_array.sv
// Byte storage model with a write guard (lockout plus per-sector protect).
// Holds 2^MEM_AW bytes. Index bits above MEM_AW are XOR-folded onto the low offset.
// Assumes MEM_AW >= ADDR_W - MEM_AW when folding is needed.
module pgm_array #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int MEM_AW = 11,
    parameter int N_SECT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] idx,
    input  logic              wr_go,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_lock,
    input  logic [N_SECT-1:0] sect_prot,
    output logic [DATA_W-1:0] rd_data
);

    localparam int SECT_W = $clog2(N_SECT);
    localparam int DEPTH  = 1 << MEM_AW;
    localparam int HI_W   = ADDR_W - MEM_AW;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [MEM_AW-1:0] off;
    logic [SECT_W-1:0] sect;
    logic              wr_ok;

    if (HI_W > 0) begin : g_fold
        // Fold the upper index bits onto the low offset.
        always_comb off = idx[MEM_AW-1:0] ^ MEM_AW'(idx[ADDR_W-1:MEM_AW]);
    end else begin : g_flat
        // Full-size model: offset is the index.
        always_comb off = idx[MEM_AW-1:0];
    end

    // Sector lookup and store permission.
    always_comb begin
        sect  = idx[ADDR_W-1 -: SECT_W];
        wr_ok = wr_go && !wr_lock && !sect_prot[sect];
    end

    // Storage write port.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[off] <= wr_data;
    end

    assign rd_data = mem[off];

    // R2: a permitted store lands where it was aimed.
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> mem[$past(off)] == $past(wr_data));

    // R10: lockout leaves the addressed byte unchanged.
    p_lock_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && wr_lock) |=> mem[$past(off)] == $past(mem[off]));

    // R11: a protected sector keeps its contents.
    p_prot_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && sect_prot[sect]) |=> mem[$past(off)] == $past(mem[off]));

endmodule

// File: rtl/pgmem_ctrl.sv
// Top of the page-mode bytewide memory controller. It samples the pins,
// sequences accesses and holds the byte array. The bus is split into
// in/out/enable; the pad ring makes it bidirectional.
// Assumes pins change at most once per few clocks (oversampled interface).
module pgmem_ctrl #(
    parameter int ADDR_W      = 17,
    parameter int COL_W       = 3,
    parameter int DATA_W      = 8,
    parameter int MEM_AW      = 11,
    parameter int N_SECT      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int T_ACC       = 6,
    parameter int T_PAGE      = 3,
    parameter int T_PRE       = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic              wr_lock,
    input  logic [N_SECT-1:0] sect_prot
);

    localparam int PIN_W = 3 + ADDR_W + DATA_W;
    localparam logic [PIN_W-1:0] PIN_RST = {3'b111, {(ADDR_W + DATA_W){1'b0}}};

    logic [PIN_W-1:0]  pins_s;
    logic              ce_s, we_s, oe_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] dq_s;
    logic [ADDR_W-1:0] acc_idx;
    logic              wr_go, drive;
    logic [DATA_W-1:0] wr_data, rd_data;

    pgm_pin_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ce_n, we_n, oe_n, addr, dq_in}),
        .q     (pins_s)
    );

    assign {ce_s, we_s, oe_s, addr_s, dq_s} = pins_s;

    pgm_access_fsm #(
        .ADDR_W (ADDR_W),
        .COL_W  (COL_W),
        .DATA_W (DATA_W),
        .T_ACC  (T_ACC),
        .T_PAGE (T_PAGE),
        .T_PRE  (T_PRE)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_s    (ce_s),
        .we_s    (we_s),
        .oe_s    (oe_s),
        .addr_s  (addr_s),
        .dq_s    (dq_s),
        .acc_idx (acc_idx),
        .wr_go   (wr_go),
        .wr_data (wr_data),
        .drive   (drive)
    );

    pgm_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .MEM_AW (MEM_AW),
        .N_SECT (N_SECT)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (acc_idx),
        .wr_go     (wr_go),
        .wr_data   (wr_data),
        .wr_lock   (wr_lock),
        .sect_prot (sect_prot),
        .rd_data   (rd_data)
    );

    // Present data only while driving.
    always_comb begin
        dq_oe  = drive;
        dq_out = drive ? rd_data : '0;
    end

endmodule

// File: tb/sim_pgmem_ctrl.sv
module sim_pgmem_ctrl;

    localparam int T_ACC  = 6;
    localparam int T_PAGE = 3;
    localparam int T_PRE  = 29;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ce_n, we_n, oe_n;
    logic [16:0] addr;
    logic [7:0]  dq_in;
    logic [7:0]  dq_out;
    logic        dq_oe;
    logic        wr_lock;
    logic [7:0]  sect_prot;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t sbq[$];
    event smp;

    always #10 clk = ~clk;

    pgmem_ctrl #(.T_ACC(T_ACC), .T_PAGE(T_PAGE), .T_PRE(T_PRE)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .wr_lock(wr_lock), .sect_prot(sect_prot)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Driver side: queue an expected byte and wake the monitor.
    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_t e;
        e.val = v;
        e.tag = tag;
        sbq.push_back(e);
        -> smp;
        tick(1);
    endtask

    // Monitor: compare queued expectations with the bus.
    initial begin
        forever begin
            @(smp);
            while (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                chk(dq_oe && dq_out == e.val, e.tag, dq_out, e.val);
            end
        end
    end

    task automatic wait_drive(input string tag);
        int k = 0;
        while (!dq_oe && k < 300) begin
            tick(1);
            k++;
        end
        chk(dq_oe, tag, dq_oe, 1);
    endtask

    task automatic close_cycle();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        tick(T_PRE + 6);
    endtask

    // CE-controlled store: CE rises first, then WE.
    task automatic wr_ce(input logic [16:0] a, input logic [7:0] d);
        we_n = 1'b0; oe_n = 1'b1; addr = a; dq_in = d; ce_n = 1'b0;
        tick(T_ACC + 4);
        ce_n = 1'b1;
        tick(3);
        we_n = 1'b1;
        tick(T_PRE + 6);
    endtask

    task automatic rd(input logic [16:0] a, input logic [7:0] v, input string tag);
        oe_n = 1'b0; we_n = 1'b1; addr = a; ce_n = 1'b0;
        wait_drive(tag);
        expect_byte(v, tag);
        close_cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        bit seen;
        rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        addr = '0; dq_in = '0; wr_lock = 1'b0; sect_prot = '0;
        tick(4);
        chk(!dq_oe, "R1", dq_oe, 0);
        rst_n = 1'b1;
        tick(3);
        oe_n = 1'b0;
        tick(3);
        chk(!dq_oe, "R1", dq_oe, 0);
        oe_n = 1'b1;
        tick(2);

        // Preload through CE-controlled stores.
        for (int i = 0; i < 8; i++) wr_ce(17'h00100 + 17'(i), 8'h20 + 8'(i));
        wr_ce(17'h08230, 8'hC3);
        wr_ce(17'h00600, 8'h11);
        wr_ce(17'h10700, 8'h77);
        wr_ce(17'h00010, 8'h5E);

        // R6: exact access time with OE already low; R2 read-back.
        oe_n = 1'b0; addr = 17'h00010; ce_n = 1'b0;
        tick(T_ACC + 2);
        chk(!dq_oe, "R6", dq_oe, 0);
        tick(1);
        chk(dq_oe, "R6", dq_oe, 1);
        expect_byte(8'h5E, "R2");
        close_cycle();

        // R6: OE high keeps the bus released after the access completes.
        oe_n = 1'b1; addr = 17'h00100; ce_n = 1'b0;
        tick(T_ACC + 6);
        chk(!dq_oe, "R6", dq_oe, 0);
        oe_n = 1'b0;
        tick(2);
        expect_byte(8'h20, "R2");

        // R3: page accesses within the open row.
        addr = 17'h00105;
        tick(T_PAGE + 2);
        chk(!dq_oe, "R3", dq_oe, 0);
        tick(1);
        chk(dq_oe, "R3", dq_oe, 1);
        expect_byte(8'h25, "R3");
        addr = 17'h00102;
        tick(T_PAGE + 2);
        chk(!dq_oe, "R3", dq_oe, 0);
        tick(1);
        expect_byte(8'h22, "R3");

        // R4: row change with CE low takes a full access.
        addr = 17'h08230;
        tick(T_ACC + 2);
        chk(!dq_oe, "R4", dq_oe, 0);
        tick(1);
        chk(dq_oe, "R4", dq_oe, 1);
        expect_byte(8'hC3, "R4");

        // R5: CE re-lowered one edge after rising waits out the precharge.
        ce_n = 1'b1;
        tick(1);
        ce_n = 1'b0; addr = 17'h00107;
        tick(T_PRE + T_ACC + 2);
        chk(!dq_oe, "R5", dq_oe, 0);
        tick(1);
        chk(dq_oe, "R5", dq_oe, 1);
        expect_byte(8'h27, "R5");
        close_cycle();

        // R7 and R8: CE-controlled write with OE low; CE rises before WE.
        we_n = 1'b0; oe_n = 1'b0; addr = 17'h14400; dq_in = 8'h33; ce_n = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < T_ACC + 6; k++) begin
            tick(1);
            if (dq_oe) seen = 1'b1;
        end
        chk(!seen, "R7", seen, 0);
        ce_n = 1'b1;
        tick(3);
        dq_in = 8'h44;
        tick(3);
        we_n = 1'b1;
        close_cycle();
        rd(17'h14400, 8'h33, "R8");

        // R8: WE-controlled write; bus released, data captured at WE rise.
        oe_n = 1'b0; we_n = 1'b1; addr = 17'h0C300; ce_n = 1'b0;
        wait_drive("R8");
        we_n = 1'b0; dq_in = 8'h5A;
        tick(2);
        chk(!dq_oe, "R8", dq_oe, 0);
        tick(2);
        we_n = 1'b1;
        tick(4);
        dq_in = 8'hFF;
        tick(2);
        close_cycle();
        rd(17'h0C300, 8'h5A, "R8");

        // R9: two write pulses in one open row.
        oe_n = 1'b1; we_n = 1'b1; addr = 17'h18501; ce_n = 1'b0;
        tick(T_ACC + 4);
        we_n = 1'b0; dq_in = 8'hA1;
        tick(3);
        we_n = 1'b1;
        tick(3);
        addr = 17'h18506;
        tick(2);
        we_n = 1'b0; dq_in = 8'hB6;
        tick(3);
        we_n = 1'b1;
        tick(3);
        close_cycle();
        rd(17'h18501, 8'hA1, "R9");
        rd(17'h18506, 8'hB6, "R9");

        // R10: lockout blocks stores, not reads.
        wr_lock = 1'b1;
        wr_ce(17'h00600, 8'h99);
        rd(17'h00600, 8'h11, "R10");
        wr_lock = 1'b0;
        wr_ce(17'h00600, 8'h9A);
        rd(17'h00600, 8'h9A, "R10");

        // R11: sector 4 protected, sector 3 still writable.
        sect_prot = 8'h10;
        wr_ce(17'h10700, 8'hEE);
        wr_ce(17'h0C710, 8'h71);
        rd(17'h10700, 8'h77, "R11");
        rd(17'h0C710, 8'h71, "R11");
        sect_prot = 8'h00;
        wr_ce(17'h10700, 8'hEF);
        rd(17'h10700, 8'hEF, "R11");

        done = 1'b1;
        summary();
    end

endmodule